// File: doc/BRIEF.md
# Clock-Control Register Slave on a Two-Wire Bus

This block is a slave-only SMBus endpoint that owns three bytes of clock-generator control state. It oversamples the bus clock and data lines with the system clock and detects START and STOP conditions. It answers one fixed write address and the read address that pairs with it. A write transfer carries a command code and a byte count, both acknowledged and otherwise ignored, then data bytes that land in register bytes 0, 1 and 2 in that order.

A read transfer answers with the byte count first, then the register bytes in the same order. Read data is built from the stored bits and from live external pin levels. Some bit positions only mirror pins, and one bit is a gated combination of a stored enable and a pin.

Downstream clock logic uses the stored control bits and the gated PCI-halt level. The register bytes keep their values from one transfer to the next until reset.

Top module: `smbclk_slave`

## Requirements
- R1: Only address byte 0xD2 (write) and 0xD3 (read) are acknowledged (SDA pulled low in the ninth clock). Any other address gets no acknowledge, and the slave leaves SDA alone until the next START.
- R2: After the write address, the next byte is a command code. Any value is acknowledged and has no effect on the registers.
- R3: The byte after the command code is a byte count and is acknowledged. Every following data byte is acknowledged and goes to register byte 0, then 1, then 2, then wraps to 0. Byte 2 is read/write in all eight bits and resets to 0x00.
- R4: In byte 0, bits 7, 6 and 5 are read/write, reset to 0, and appear on cfg_o[7:5].
- R5: In byte 0, bit 4 reads the cpu_halt_n_pin level and bits 2:0 read fsel_pin[2:0]. Writes to these positions are discarded.
- R6: Byte 0 bit 3 holds a stored PCI enable that resets to 1. It reads back as that stored bit AND pci_halt_n_pin, and pci_halt_n_o carries the same AND.
- R7: In byte 1, bit 7 reads mul_pin and ignores writes. Bits 6:0 are read/write and reset to 0x07.
- R8: After 0xD3 is acknowledged, the slave sends the byte count 3, then bytes 0, 1, 2, 0, and so on, MSB first. It continues while the master acknowledges and releases SDA after a master NACK.
- R9: A repeated START returns the slave to address reception. A STOP ends the transfer. Register contents persist across transfers.
- R10: The slave changes its SDA drive only while SCL is low.
- R11: Reset gives cfg_o = 0x000708 and no SDA drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock, oversamples the bus |
| rst_n | input | 1 | asynchronous active-low reset |
| scl_i | input | 1 | bus clock line level |
| sda_i | input | 1 | bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| cpu_halt_n_pin | input | 1 | CPU halt pin, mirrored in byte 0 bit 4 |
| pci_halt_n_pin | input | 1 | PCI halt pin, gated into byte 0 bit 3 |
| fsel_pin | input | 3 | frequency select pins, mirrored in byte 0 bits 2:0 |
| mul_pin | input | 1 | multiplier strap, mirrored in byte 1 bit 7 |
| cfg_o | output | 24 | stored bits {byte2, byte1, byte0}; read-only positions are 0 |
| pci_halt_n_o | output | 1 | stored PCI enable AND pci_halt_n_pin |

## Verification
The hardest case to reach is the index wrap in both directions: a fourth data byte in one write must overwrite byte 0, and a fourth read byte must return byte 0 again. The bench gets there by running single transfers longer than the register bank, with an acknowledge on every read byte before the final NACK. A repeated START issued in the middle of a write, straight into a read, covers the return to address reception without a STOP. Pin levels are changed between reads so that each mirrored bit is seen in both states.

// File: rtl/smbclk_pkg.sv
package smbclk_pkg;
   localparam int NBYTES = 3;
   localparam int IDX_W  = 2;

   typedef enum logic [2:0] {
      S_IDLE, S_RX, S_ACK, S_TX, S_MACK, S_WAIT
   } xfer_st_t;

   typedef enum logic [1:0] {
      G_ADDR, G_CMD, G_CNT, G_DATA
   } stage_t;

   // writable positions per byte; the rest are pin mirrors
   function automatic logic [7:0] rw_mask(input int b);
      case (b)
         0:       return 8'hE8;
         1:       return 8'h7F;
         default: return 8'hFF;
      endcase
   endfunction

   function automatic logic [7:0] rst_val(input int b);
      case (b)
         0:       return 8'h08;
         1:       return 8'h07;
         default: return 8'h00;
      endcase
   endfunction
endpackage

// File: rtl/smbclk_linesync.sv
module smbclk_linesync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_p, sda_p;
   logic              scl_q, sda_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("smbclk_linesync: STAGES must be at least 2");
      end
      for (genvar k = 0; k < STAGES; k++) begin : g_chain
         if (k == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) begin
                  scl_p[0] <= 1'b1;
                  sda_p[0] <= 1'b1;
               end else begin
                  scl_p[0] <= scl_i;
                  sda_p[0] <= sda_i;
               end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) begin
                  scl_p[k] <= 1'b1;
                  sda_p[k] <= 1'b1;
               end else begin
                  scl_p[k] <= scl_p[k-1];
                  sda_p[k] <= sda_p[k-1];
               end
         end
      end
   endgenerate

   assign scl_s = scl_p[STAGES-1];
   assign sda_s = sda_p[STAGES-1];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smbclk_xfer.sv
module smbclk_xfer
   import smbclk_pkg::*;
#(
   parameter logic [7:0] WR_ADDR = 8'hD2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sda_s,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             start_det,
   input  logic             stop_det,
   input  logic [7:0]       rd_data,
   output logic [IDX_W-1:0] rd_idx,
   output logic             wr_stb,
   output logic [IDX_W-1:0] wr_idx,
   output logic [7:0]       wr_data,
   output logic             sda_oe
);
   localparam logic [7:0] RD_ADDR = WR_ADDR | 8'h01;
   localparam logic [7:0] COUNT_B = 8'(NBYTES);

   xfer_st_t         st;
   stage_t           stage;
   logic             rw;
   logic             ack_seen;
   logic [3:0]       cnt;
   logic [7:0]       shreg;
   logic [IDX_W-1:0] idx;

   function automatic logic [IDX_W-1:0] idx_next(input logic [IDX_W-1:0] i);
      return (i == IDX_W'(NBYTES - 1)) ? '0 : i + 1'b1;
   endfunction

   assign rd_idx = idx;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         st       <= S_IDLE;
         stage    <= G_ADDR;
         rw       <= 1'b0;
         ack_seen <= 1'b0;
         cnt      <= '0;
         shreg    <= '0;
         idx      <= '0;
         wr_stb   <= 1'b0;
         wr_idx   <= '0;
         wr_data  <= '0;
         sda_oe   <= 1'b0;
      end else begin
         wr_stb <= 1'b0;
         if (start_det) begin
            st     <= S_RX;
            stage  <= G_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            st     <= S_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (st)
               S_RX: begin
                  if (scl_rise && cnt != 4'd8) begin
                     shreg <= {shreg[6:0], sda_s};
                     cnt   <= cnt + 4'd1;
                  end else if (scl_fall && cnt == 4'd8) begin
                     cnt <= '0;
                     case (stage)
                        G_ADDR: begin
                           if (shreg == WR_ADDR) begin
                              sda_oe <= 1'b1;
                              st     <= S_ACK;
                              rw     <= 1'b0;
                              stage  <= G_CMD;
                           end else if (shreg == RD_ADDR) begin
                              sda_oe <= 1'b1;
                              st     <= S_ACK;
                              rw     <= 1'b1;
                              stage  <= G_CNT;
                              idx    <= '0;
                           end else begin
                              st <= S_WAIT;
                           end
                        end
                        G_CMD: begin
                           sda_oe <= 1'b1;
                           st     <= S_ACK;
                           stage  <= G_CNT;
                        end
                        G_CNT: begin
                           sda_oe <= 1'b1;
                           st     <= S_ACK;
                           stage  <= G_DATA;
                           idx    <= '0;
                        end
                        default: begin
                           sda_oe  <= 1'b1;
                           st      <= S_ACK;
                           wr_stb  <= 1'b1;
                           wr_idx  <= idx;
                           wr_data <= shreg;
                           idx     <= idx_next(idx);
                        end
                     endcase
                  end
               end
               S_ACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (rw) begin
                        st <= S_TX;
                        if (stage == G_CNT) begin
                           shreg  <= COUNT_B;
                           sda_oe <= ~COUNT_B[7];
                           stage  <= G_DATA;
                        end else begin
                           shreg  <= rd_data;
                           sda_oe <= ~rd_data[7];
                           idx    <= idx_next(idx);
                        end
                     end else begin
                        sda_oe <= 1'b0;
                        st     <= S_RX;
                     end
                  end
               end
               S_TX: begin
                  if (scl_rise) begin
                     cnt <= cnt + 4'd1;
                  end else if (scl_fall) begin
                     if (cnt == 4'd8) begin
                        sda_oe   <= 1'b0;
                        st       <= S_MACK;
                        ack_seen <= 1'b0;
                     end else begin
                        shreg  <= {shreg[6:0], 1'b0};
                        sda_oe <= ~shreg[6];
                     end
                  end
               end
               S_MACK: begin
                  if (scl_rise) begin
                     ack_seen <= ~sda_s;
                  end else if (scl_fall) begin
                     if (ack_seen) begin
                        st     <= S_TX;
                        cnt    <= '0;
                        shreg  <= rd_data;
                        sda_oe <= ~rd_data[7];
                        idx    <= idx_next(idx);
                     end else begin
                        st <= S_WAIT;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
endmodule

// File: rtl/smbclk_regbank.sv
module smbclk_regbank
   import smbclk_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_stb,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic [7:0]          wr_data,
   input  logic [IDX_W-1:0]    rd_idx,
   output logic [7:0]          rd_data,
   input  logic                cpu_halt_n_pin,
   input  logic                pci_halt_n_pin,
   input  logic [2:0]          fsel_pin,
   input  logic                mul_pin,
   output logic [NBYTES*8-1:0] cfg_o,
   output logic                pci_halt_n_o
);
   logic [7:0] q      [NBYTES];
   logic [7:0] rd_val [NBYTES];

   generate
      if (NBYTES != 3) begin : g_bad
         $error("smbclk_regbank: bank layout assumes three bytes");
      end
      for (genvar g = 0; g < NBYTES; g++) begin : g_byte
         localparam logic [7:0] M = rw_mask(g);
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)
               q[g] <= rst_val(g);
            else if (wr_stb && wr_idx == IDX_W'(g))
               q[g] <= (q[g] & ~M) | (wr_data & M);

         assign cfg_o[g*8 +: 8] = q[g];

         if (g == 0) begin : g_b0
            assign rd_val[g] = {q[g][7:5], cpu_halt_n_pin,
                                q[g][3] & pci_halt_n_pin, fsel_pin};
         end else if (g == 1) begin : g_b1
            assign rd_val[g] = {mul_pin, q[g][6:0]};
         end else begin : g_bn
            assign rd_val[g] = q[g];
         end
      end
   endgenerate

   assign pci_halt_n_o = q[0][3] & pci_halt_n_pin;

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NBYTES; i++)
         if (rd_idx == IDX_W'(i)) rd_data = rd_val[i];
   end
endmodule

// File: rtl/smbclk_slave.sv
module smbclk_slave
   import smbclk_pkg::*;
#(
   parameter logic [7:0] WR_ADDR     = 8'hD2,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                scl_i,
   input  logic                sda_i,
   output logic                sda_oe,
   input  logic                cpu_halt_n_pin,
   input  logic                pci_halt_n_pin,
   input  logic [2:0]          fsel_pin,
   input  logic                mul_pin,
   output logic [NBYTES*8-1:0] cfg_o,
   output logic                pci_halt_n_o
);
   generate
      if (WR_ADDR[0] != 1'b0) begin : g_bad_addr
         $error("smbclk_slave: WR_ADDR must have bit 0 clear");
      end
   endgenerate

   logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic             wr_stb;
   logic [IDX_W-1:0] wr_idx, rd_idx;
   logic [7:0]       wr_data, rd_data;

   smbclk_linesync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   smbclk_xfer #(.WR_ADDR(WR_ADDR)) u_xfer (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
      .rd_data(rd_data), .rd_idx(rd_idx), .wr_stb(wr_stb), .wr_idx(wr_idx),
      .wr_data(wr_data), .sda_oe(sda_oe)
   );

   smbclk_regbank u_regs (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
      .cpu_halt_n_pin(cpu_halt_n_pin), .pci_halt_n_pin(pci_halt_n_pin),
      .fsel_pin(fsel_pin), .mul_pin(mul_pin), .cfg_o(cfg_o),
      .pci_halt_n_o(pci_halt_n_o)
   );
endmodule

// File: rtl/smbclk_checker.sv
module smbclk_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        scl_i,
   input logic        sda_oe,
   input logic [23:0] cfg_o,
   input logic        pci_halt_n_pin,
   input logic        pci_halt_n_o,
   input logic        wr_stb,
   input logic        stop_det
);
   // R11: reset values
   a_r11_reset_value: assert property (@(posedge clk)
      !rst_n |=> (cfg_o == 24'h000708 && !sda_oe));

   // R10: drive edges only while the bus clock is low
   a_r10_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_i);

   // R9: registers hold unless the transfer engine strobed a write
   a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_stb) |-> $stable(cfg_o));

   // R6: a low PCI halt pin always forces the gated output low
   a_r6_pci_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !pci_halt_n_pin |-> !pci_halt_n_o);

   // R9: after STOP the slave does not drive the line
   a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stop_det) |-> !sda_oe);
endmodule

bind smbclk_slave smbclk_checker u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .cfg_o(cfg_o),
   .pci_halt_n_pin(pci_halt_n_pin), .pci_halt_n_o(pci_halt_n_o),
   .wr_stb(wr_stb), .stop_det(stop_det)
);

// File: tb/sim_smbclk_slave.sv
module sim_smbclk_slave;
   localparam int Q = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m_scl = 1'b1, m_sda = 1'b1;
   logic        sda_oe;
   logic        cpu_n = 1'b1, pci_n = 1'b1, mul = 1'b0;
   logic [2:0]  fsel = 3'b000;
   logic [23:0] cfg;
   logic        pci_o;
   logic        sda_line;
   int          n_run = 0, n_fail = 0;
   bit          done = 1'b0;
   logic [7:0]  st [3];

   assign sda_line = m_sda & ~sda_oe;

   always #2 clk = ~clk;

   smbclk_slave u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
      .sda_oe(sda_oe), .cpu_halt_n_pin(cpu_n), .pci_halt_n_pin(pci_n),
      .fsel_pin(fsel), .mul_pin(mul), .cfg_o(cfg), .pci_halt_n_o(pci_o)
   );

   function automatic logic [7:0] mask_of(int i);
      return (i == 0) ? 8'hE8 : (i == 1) ? 8'h7F : 8'hFF;
   endfunction

   function automatic logic [7:0] exp_rd(int i);
      if (i == 0) return {st[0][7:5], cpu_n, st[0][3] & pci_n, fsel};
      if (i == 1) return {mul, st[1][6:0]};
      return st[2];
   endfunction

   task automatic model_wr(int i, logic [7:0] d);
      st[i] = (st[i] & ~mask_of(i)) | (d & mask_of(i));
   endtask

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(posedge clk);
      #1;
   endtask

   task automatic bus_start();
      m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
   endtask

   task automatic wr_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
      end
      m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); ack = ~sda_line; wq(); m_scl = 1'b0; wq();
   endtask

   task automatic rd_byte(output logic [7:0] b, input logic nack);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq(); m_scl = 1'b1; wq(); b[i] = sda_line; wq(); m_scl = 1'b0; wq();
      end
      m_sda = nack; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
      m_sda = 1'b1;
   endtask

   // full write: address, command, count, then data
   task automatic do_write(logic [7:0] cmd, int n, logic [7:0] d0, logic [7:0] d1,
                           logic [7:0] d2, logic [7:0] d3);
      logic a;
      logic [7:0] d [4];
      d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
      bus_start();
      wr_byte(8'hD2, a); chk(a, "R1 write addr ack", {31'd0, a}, 1);
      wr_byte(cmd, a);   chk(a, "R2 command ack", {31'd0, a}, 1);
      wr_byte(8'(n), a); chk(a, "R3 count ack", {31'd0, a}, 1);
      for (int i = 0; i < n; i++) begin
         wr_byte(d[i], a);
         chk(a, "R3 data ack", {31'd0, a}, 1);
         model_wr(i % 3, d[i]);
      end
      bus_stop();
   endtask

   // full read: count then n bytes, NACK on the last
   task automatic do_read(int n);
      logic a;
      logic [7:0] b;
      bus_start();
      wr_byte(8'hD3, a); chk(a, "R1 read addr ack", {31'd0, a}, 1);
      rd_byte(b, 1'b0);  chk(b == 8'd3, "R8 count byte", {24'd0, b}, 3);
      for (int i = 0; i < n; i++) begin
         rd_byte(b, i == n - 1);
         chk(b == exp_rd(i % 3), "R8 read data (R5 R6 R7 fields)", {24'd0, b},
             {24'd0, exp_rd(i % 3)});
      end
      wq();
      chk(sda_line == 1'b1 && !sda_oe, "R8 released after NACK", {31'd0, sda_oe}, 0);
      bus_stop();
   endtask

   function automatic logic [23:0] exp_cfg();
      return {st[2], st[1], st[0]};
   endfunction

   initial begin
      logic a;
      logic [7:0] b;
      st[0] = 8'h08; st[1] = 8'h07; st[2] = 8'h00;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      wq();
      // R11 reset state
      chk(cfg == 24'h000708, "R11 reset cfg", {8'd0, cfg}, 32'h000708);
      chk(!sda_oe, "R11 no drive", {31'd0, sda_oe}, 0);
      chk(pci_o == 1'b1, "R6 reset gate", {31'd0, pci_o}, 1);
      chk(cfg[7:5] == 3'b000, "R4 reset bits", {29'd0, cfg[7:5]}, 0);

      // R1 sweep over all even addresses: only 0xD2 is acknowledged
      for (int ad = 0; ad < 256; ad += 2) begin
         bus_start();
         wr_byte(8'(ad), a);
         chk(a == (ad == 8'hD2), "R1 address sweep", {31'd0, a}, {31'd0, ad == 8'hD2});
         bus_stop();
      end
      chk(cfg == exp_cfg(), "R1 sweep leaves regs", {8'd0, cfg}, {8'd0, exp_cfg()});

      // non-matching odd address: no ack, line left alone afterwards
      bus_start();
      wr_byte(8'hD5, a);
      chk(!a, "R1 odd foreign addr nack", {31'd0, a}, 0);
      wr_byte(8'h00, a);
      chk(!a, "R1 silent until START", {31'd0, a}, 0);
      bus_stop();

      // R2 R3 R4 R5 R7 write all ones / zeros / pattern
      do_write(8'h5A, 3, 8'hFF, 8'h00, 8'hA5, 8'h00);
      chk(cfg == exp_cfg(), "R3 R4 R5 R7 cfg after write", {8'd0, cfg}, {8'd0, exp_cfg()});
      chk(cfg[4] == 1'b0 && cfg[2:0] == 3'b000, "R5 RO positions unwritten",
          {27'd0, cfg[4:0]}, {27'd0, exp_cfg()[4:0]});

      // R5 R6 R7 R8 reads under two pin patterns
      cpu_n = 1'b1; pci_n = 1'b1; fsel = 3'b101; mul = 1'b1;
      do_read(4);
      cpu_n = 1'b0; pci_n = 1'b0; fsel = 3'b010; mul = 1'b0;
      wq();
      chk(pci_o == 1'b0, "R6 pin low gates output", {31'd0, pci_o}, 0);
      do_read(3);

      // R3 wrap on write, R6 stored bit cleared, R2 other command value
      pci_n = 1'b1;
      do_write(8'hFF, 4, 8'h17, 8'hFF, 8'h3C, 8'h20);
      chk(cfg == exp_cfg(), "R3 write wrap to byte 0", {8'd0, cfg}, {8'd0, exp_cfg()});
      wq();
      chk(pci_o == 1'b0, "R6 stored enable clear", {31'd0, pci_o}, 0);
      chk(cfg[15] == 1'b0 && cfg[14:8] == 7'h7F, "R7 byte1 rw", {24'd0, cfg[15:8]}, 32'h7F);
      do_read(6);

      // R9 repeated START from mid-write into read
      bus_start();
      wr_byte(8'hD2, a); wr_byte(8'h00, a); wr_byte(8'h03, a);
      wr_byte(8'hC8, a); model_wr(0, 8'hC8);
      chk(a, "R9 data ack before restart", {31'd0, a}, 1);
      bus_start();
      wr_byte(8'hD3, a);
      chk(a, "R9 restart addr ack", {31'd0, a}, 1);
      rd_byte(b, 1'b0);
      chk(b == 8'd3, "R9 count after restart", {24'd0, b}, 3);
      rd_byte(b, 1'b1);
      chk(b == exp_rd(0), "R9 byte0 after restart", {24'd0, b}, {24'd0, exp_rd(0)});
      wq();
      bus_stop();
      repeat (20) wq();
      chk(cfg == exp_cfg(), "R9 retained", {8'd0, cfg}, {8'd0, exp_cfg()});
      chk(pci_o == 1'b1, "R6 enable set with pin high", {31'd0, pci_o}, 1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule